// File: doc/BRIEF.md
# Static-Memory Bus Cycle Generator

This block turns single requests from an internal host into timed bus cycles for static-memory-style devices. Two address regions are decoded from address bits 28 to 26. Each region has its own active-low chip select. During an access the block drives the latched address and write data. It lowers a read strobe that can serve as an output enable, or active-low byte-lane write strobes. The strobe is framed by a programmable setup phase before it and a programmable hold phase after it.

Each region has its own configuration inputs. These set the setup length (0 or 1 cycle), the hold length (0 to 3 cycles), a coded internal wait count and a data width. During the last programmed wait cycle, an external wait input can stretch the strobe for as long as it is held high. The host holds `req_valid` until it sees the one-cycle `req_ack`. An address outside both regions is acknowledged without any bus activity.

The controller is a five-state machine:
- ST_IDLE waits for a request. It moves to ST_ACK on an address outside both regions. Otherwise it moves to ST_SETUP when setup is 1, or to ST_STROBE when setup is 0.
- ST_SETUP lasts one cycle and moves to ST_STROBE.
- ST_STROBE counts down the wait cycles. Once the count is exhausted and external wait is low, it moves to ST_HOLD when hold is greater than 0, or to ST_ACK when hold is 0.
- ST_HOLD counts the hold cycles and then moves to ST_ACK.
- ST_ACK always returns to ST_IDLE.

Top module: `sbc_bus_cycle_gen`

## Requirements
- R1: An access whose address bits 28:26 equal 3'b100 lowers only `bus_cs_n[0]`, and one with 3'b101 lowers only `bus_cs_n[1]`. At most one chip select is low at any time.
- R2: When the region's setup bit is 1, the chip select is low for exactly one cycle before the strobe. When the bit is 0, the chip select and the strobe fall together.
- R3: The strobe stays low for 1+W cycles, where W is decoded from the region's 3-bit wait code: 0,1,2,3,4,5,6,7 give 0,1,2,3,4,6,8,12.
- R4: `ext_wait` is sampled only in the last programmed strobe cycle and in any extension after it. Each clock edge at which it is high adds one strobe cycle. It has no effect in any other cycle.
- R5: After the strobe ends, the chip select stays low for exactly H cycles, where H is the region's 2-bit hold value (0 to 3).
- R6: During a write strobe, `bus_we_n[i]` is low exactly when `req_be[i]` is set and lane i lies inside the region's width. Size code 0, 1, 2 and 3 enables lanes 0, 0..1, 0..3 and 0..7 respectively. All write strobes are high during reads and outside the strobe.
- R7: `bus_rd_n` is low only during the strobe of a read access, and never during a write.
- R8: `req_ack` is high for exactly one cycle, in the cycle after the hold phase ends. For a decoded access, the ack is seen 1+S+(1+W+E)+H cycles after the request is accepted, where S is the setup length, W the decoded wait count, E the number of extension cycles and H the hold length.
- R9: `rsp_rdata` holds the value that `bus_rdata` had at the clock edge that ends a read strobe.
- R10: An access whose address bits 28:26 are neither 3'b100 nor 3'b101 is acknowledged in the cycle after acceptance. No chip select and no strobe goes low.
- R11: While reset is applied and after it, all chip selects and strobes are high and `req_ack` is low.
- R12: `bus_addr` and `bus_wdata` equal the request's address and data, and stay stable while a chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request; held until ack |
| req_addr | input | ADDR_W | Request address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_be | input | BE_W | Byte enables |
| req_wdata | input | DATA_W | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| cfg_setup | input | NUM_REG | Per-region setup bit |
| cfg_hold | input | 2*NUM_REG | Per-region hold value |
| cfg_wait | input | 3*NUM_REG | Per-region wait code |
| cfg_size | input | 2*NUM_REG | Per-region width code |
| ext_wait | input | 1 | External wait, active high |
| bus_addr | output | ADDR_W | Bus address |
| bus_cs_n | output | NUM_REG | Chip selects, active low |
| bus_rd_n | output | 1 | Read strobe / output enable, active low |
| bus_we_n | output | BE_W | Byte-lane write strobes, active low |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdata | input | DATA_W | Bus read data |

## Verification
Random accesses mix both regions with unmapped addresses, reads with writes, every setup, hold, wait code and width, and 0 to 3 extension cycles. A per-cycle trace of chip select and strobes separates the setup, strobe and hold lengths, and the ack latency confirms their sum. `ext_wait` is driven high during early wait cycles and random in setup and hold cycles, which tells correct sampling in the final wait cycle apart from sampling at the wrong time. The read data bus changes every cycle, so a capture one edge early or late gives a wrong value. Directed cases cover the longest frame, the shortest frame and a narrow 8-bit write.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_ACK
    } sbc_state_e;

    typedef struct packed {
        logic       setup;
        logic [1:0] hold;
        logic [3:0] waits;
        logic [1:0] size;
    } sbc_timing_t;

    // Coded wait field to cycle count; the largest code stays below 16.
    function automatic logic [3:0] wait_decode(input logic [2:0] code);
        logic [3:0] n;
        unique case (code)
            3'd4:    n = 4'd4;
            3'd5:    n = 4'd6;
            3'd6:    n = 4'd8;
            3'd7:    n = 4'd12;
            default: n = {1'b0, code};
        endcase
        return n;
    endfunction

endpackage

// File: rtl/sbc_region_decode.sv
module sbc_region_decode #(
    parameter int SEL_W     = 3,
    parameter int NUM_REG   = 2,
    parameter int BASE_CODE = 4,
    localparam int IDX_W    = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
    input  logic [SEL_W-1:0] sel,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    logic [NUM_REG-1:0] match;

    for (genvar g = 0; g < NUM_REG; g++) begin : g_match
        assign match[g] = (sel == SEL_W'(BASE_CODE + g));
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < NUM_REG; i++) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end

    assign hit = |match;
endmodule

// File: rtl/sbc_timing_sel.sv
module sbc_timing_sel
    import sbc_pkg::*;
#(
    parameter int NUM_REG = 2,
    localparam int IDX_W  = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
    input  logic [NUM_REG-1:0]   cfg_setup,
    input  logic [2*NUM_REG-1:0] cfg_hold,
    input  logic [3*NUM_REG-1:0] cfg_wait,
    input  logic [2*NUM_REG-1:0] cfg_size,
    input  logic [IDX_W-1:0]     idx,
    output sbc_timing_t          timing
);
    sbc_timing_t per_reg [NUM_REG];

    for (genvar g = 0; g < NUM_REG; g++) begin : g_unpack
        assign per_reg[g].setup = cfg_setup[g];
        assign per_reg[g].hold  = cfg_hold[2*g +: 2];
        assign per_reg[g].waits = wait_decode(cfg_wait[3*g +: 3]);
        assign per_reg[g].size  = cfg_size[2*g +: 2];
    end

    always_comb begin
        timing = per_reg[0];
        for (int i = 0; i < NUM_REG; i++) begin
            if (idx == IDX_W'(i)) timing = per_reg[i];
        end
    end
endmodule

// File: rtl/sbc_lane_gen.sv
module sbc_lane_gen #(
    parameter int BE_W = 8
) (
    input  logic            strobe_wr,
    input  logic [1:0]      size,
    input  logic [BE_W-1:0] be,
    output logic [BE_W-1:0] we_n
);
    for (genvar g = 0; g < BE_W; g++) begin : g_lane
        logic in_width;
        assign in_width = (32'(g) < (32'd1 << size));
        assign we_n[g]  = !(strobe_wr && be[g] && in_width);
    end
endmodule

// File: rtl/sbc_bus_cycle_gen.sv
module sbc_bus_cycle_gen
    import sbc_pkg::*;
#(
    parameter int ADDR_W   = 29,
    parameter int DATA_W   = 64,
    parameter int NUM_REG  = 2,
    parameter int SEL_LSB  = 26,
    parameter int SEL_W    = 3,
    parameter int BASE_SEL = 4,
    localparam int BE_W    = DATA_W / 8,
    localparam int IDX_W   = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 req_we,
    input  logic [BE_W-1:0]      req_be,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 req_ack,
    output logic [DATA_W-1:0]    rsp_rdata,
    input  logic [NUM_REG-1:0]   cfg_setup,
    input  logic [2*NUM_REG-1:0] cfg_hold,
    input  logic [3*NUM_REG-1:0] cfg_wait,
    input  logic [2*NUM_REG-1:0] cfg_size,
    input  logic                 ext_wait,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic [NUM_REG-1:0]   bus_cs_n,
    output logic                 bus_rd_n,
    output logic [BE_W-1:0]      bus_we_n,
    output logic [DATA_W-1:0]    bus_wdata,
    input  logic [DATA_W-1:0]    bus_rdata
);
    sbc_state_e  state_q, state_d;
    logic [3:0]  wcnt_q, wcnt_d;
    logic [1:0]  hcnt_q, hcnt_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic [BE_W-1:0]   be_q;
    logic        we_q, hit_q;
    logic [IDX_W-1:0] idx_q;
    sbc_timing_t tim_q;

    logic        dec_hit;
    logic [IDX_W-1:0] dec_idx;
    sbc_timing_t tim_in;
    logic        take_req, take_rd;
    logic        cs_on, strobe_wr;

    sbc_region_decode #(
        .SEL_W(SEL_W), .NUM_REG(NUM_REG), .BASE_CODE(BASE_SEL)
    ) u_dec (
        .sel(req_addr[SEL_LSB +: SEL_W]), .hit(dec_hit), .idx(dec_idx)
    );

    sbc_timing_sel #(.NUM_REG(NUM_REG)) u_tim (
        .cfg_setup(cfg_setup), .cfg_hold(cfg_hold), .cfg_wait(cfg_wait),
        .cfg_size(cfg_size), .idx(dec_idx), .timing(tim_in)
    );

    // Next state and counters.
    always_comb begin
        state_d  = state_q;
        wcnt_d   = wcnt_q;
        hcnt_d   = hcnt_q;
        take_req = 1'b0;
        take_rd  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    take_req = 1'b1;
                    if (!dec_hit) begin
                        state_d = ST_ACK;
                    end else if (tim_in.setup) begin
                        state_d = ST_SETUP;
                    end else begin
                        state_d = ST_STROBE;
                        wcnt_d  = tim_in.waits;
                    end
                end
            end
            ST_SETUP: begin
                state_d = ST_STROBE;
                wcnt_d  = tim_q.waits;
            end
            ST_STROBE: begin
                if (wcnt_q != 4'd0) begin
                    wcnt_d = wcnt_q - 4'd1;
                end else if (!ext_wait) begin
                    take_rd = !we_q;
                    if (tim_q.hold == 2'd0) begin
                        state_d = ST_ACK;
                    end else begin
                        state_d = ST_HOLD;
                        hcnt_d  = tim_q.hold;
                    end
                end
            end
            ST_HOLD: begin
                if (hcnt_q == 2'd1) state_d = ST_ACK;
                else                hcnt_d  = hcnt_q - 2'd1;
            end
            ST_ACK:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and request capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wcnt_q  <= '0;
            hcnt_q  <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            be_q    <= '0;
            we_q    <= 1'b0;
            hit_q   <= 1'b0;
            idx_q   <= '0;
            tim_q   <= '0;
        end else begin
            state_q <= state_d;
            wcnt_q  <= wcnt_d;
            hcnt_q  <= hcnt_d;
            if (take_req) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                be_q    <= req_be;
                we_q    <= req_we;
                hit_q   <= dec_hit;
                idx_q   <= dec_idx;
                tim_q   <= tim_in;
            end
            if (take_rd) rdata_q <= bus_rdata;
        end
    end

    // Outputs.
    always_comb begin
        cs_on     = hit_q && (state_q == ST_SETUP || state_q == ST_STROBE ||
                              state_q == ST_HOLD);
        strobe_wr = (state_q == ST_STROBE) && we_q;
        bus_rd_n  = !((state_q == ST_STROBE) && !we_q);
        req_ack   = (state_q == ST_ACK);
        for (int i = 0; i < NUM_REG; i++) begin
            bus_cs_n[i] = !(cs_on && idx_q == IDX_W'(i));
        end
    end

    assign bus_addr  = addr_q;
    assign bus_wdata = wdata_q;
    assign rsp_rdata = rdata_q;

    sbc_lane_gen #(.BE_W(BE_W)) u_lane (
        .strobe_wr(strobe_wr), .size(tim_q.size), .be(be_q), .we_n(bus_we_n)
    );

    a_r1_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~bus_cs_n));
    a_r7_rd_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> !(&bus_cs_n));
    a_r6_no_write_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> (&bus_we_n));
    a_r8_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);
    a_r10_ack_cs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> (&bus_cs_n) && bus_rd_n && (&bus_we_n));
    a_r12_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&bus_cs_n) && $past(!(&bus_cs_n))) |-> $stable(bus_addr) && $stable(bus_wdata));
endmodule

// File: tb/tb_sbc_bus_cycle_gen.sv
module tb_sbc_bus_cycle_gen;
    localparam int ADDR_W = 29;
    localparam int DATA_W = 64;
    localparam int BE_W   = 8;
    localparam int NREG   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic req_we = 1'b0;
    logic [BE_W-1:0] req_be = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic req_ack;
    logic [DATA_W-1:0] rsp_rdata;
    logic [NREG-1:0] cfg_setup = '0;
    logic [2*NREG-1:0] cfg_hold = '0;
    logic [3*NREG-1:0] cfg_wait = '0;
    logic [2*NREG-1:0] cfg_size = '0;
    logic ext_wait = 1'b0;
    logic [ADDR_W-1:0] bus_addr;
    logic [NREG-1:0] bus_cs_n;
    logic bus_rd_n;
    logic [BE_W-1:0] bus_we_n;
    logic [DATA_W-1:0] bus_wdata;
    logic [DATA_W-1:0] bus_rdata = '0;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    sbc_bus_cycle_gen dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_we(req_we), .req_be(req_be), .req_wdata(req_wdata),
        .req_ack(req_ack), .rsp_rdata(rsp_rdata), .cfg_setup(cfg_setup),
        .cfg_hold(cfg_hold), .cfg_wait(cfg_wait), .cfg_size(cfg_size),
        .ext_wait(ext_wait), .bus_addr(bus_addr), .bus_cs_n(bus_cs_n),
        .bus_rd_n(bus_rd_n), .bus_we_n(bus_we_n), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int wait_cycles(input int code);
        case (code)
            4: return 4;
            5: return 6;
            6: return 8;
            7: return 12;
            default: return code;
        endcase
    endfunction

    function automatic logic [BE_W-1:0] width_mask(input int sz);
        return BE_W'((1 << (1 << sz)) - 1);
    endfunction

    // One access: region 0/1 or 2 = unmapped.
    task automatic run_access(input int reg_sel, input bit we, input logic [BE_W-1:0] be,
                              input int s, input int h, input int wcode, input int sz,
                              input int ext);
        logic [ADDR_W-1:0] a;
        logic [DATA_W-1:0] wd;
        logic [DATA_W-1:0] last_rd = '0;
        int cyc = 0, n_setup = 0, n_strobe = 0, n_hold = 0;
        bit seen_strobe = 0, ack_seen = 0;
        bit cs_bad = 0, we_bad = 0, rd_bad = 0, data_bad = 0, any_cs = 0, any_strobe = 0;
        int w = wait_cycles(wcode);
        int exp_strobe = 1 + w + ext;
        int exp_lat;
        logic [BE_W-1:0] exp_we_n = ~(be & width_mask(sz));
        logic [2:0] code;
        if (reg_sel == 0) code = 3'b100;
        else if (reg_sel == 1) code = 3'b101;
        else begin
            code = 3'($urandom_range(0, 5));
            if (code >= 3'b100) code = code + 3'd2;
        end
        a = {code, 26'($urandom)};
        wd = {$urandom, $urandom};
        exp_lat = (reg_sel > 1) ? 1 : 1 + s + exp_strobe + h;
        // Load config for the target region, scramble the other one.
        cfg_setup = NREG'($urandom); cfg_hold = 4'($urandom);
        cfg_wait = 6'($urandom); cfg_size = 4'($urandom);
        if (reg_sel < 2) begin
            cfg_setup[reg_sel] = s[0];
            cfg_hold[2*reg_sel +: 2] = h[1:0];
            cfg_wait[3*reg_sel +: 3] = wcode[2:0];
            cfg_size[2*reg_sel +: 2] = sz[1:0];
        end
        req_addr = a; req_we = we; req_be = be; req_wdata = wd; req_valid = 1'b1;
        while (!ack_seen && cyc < 64) begin
            @(negedge clk);
            cyc++;
            if (req_ack) begin
                ack_seen = 1;
                req_valid = 1'b0;
            end
            if (!(&bus_cs_n)) begin
                any_cs = 1;
                if (reg_sel > 1 || bus_cs_n != ~(NREG'(1) << reg_sel)) cs_bad = 1;
                if (bus_addr != a || bus_wdata != wd) data_bad = 1;
            end
            if (!bus_rd_n || !(&bus_we_n)) begin
                any_strobe = 1;
                seen_strobe = 1;
                n_strobe++;
                if (we && (bus_we_n != exp_we_n || !bus_rd_n)) we_bad = 1;
                if (!we && (bus_rd_n || !(&bus_we_n))) rd_bad = 1;
            end else begin
                if (!(&bus_we_n)) we_bad = 1;
                if (!(&bus_cs_n)) begin
                    if (seen_strobe) n_hold++;
                    else n_setup++;
                end
            end
            // Drive for the coming edge.
            if (!bus_rd_n || !(&bus_we_n)) ext_wait = (n_strobe < exp_strobe);
            else ext_wait = 1'($urandom);
            bus_rdata = {$urandom, $urandom};
            if (!bus_rd_n) last_rd = bus_rdata;
        end
        chk(ack_seen && cyc == exp_lat, "R8 ack latency", cyc, exp_lat);
        if (reg_sel > 1) begin
            chk(!any_cs && !any_strobe, "R10 unmapped access quiet", any_cs, 0);
        end else begin
            chk(any_cs && !cs_bad, "R1 chip select line", bus_cs_n, reg_sel);
            chk(n_setup == s, "R2 setup cycles", n_setup, s);
            chk(n_strobe == exp_strobe, (ext > 0) ? "R4 extended strobe cycles" : "R3 strobe cycles",
                n_strobe, exp_strobe);
            chk(n_hold == h, "R5 hold cycles", n_hold, h);
            chk(!data_bad, "R12 address and data", data_bad, 0);
            if (we) chk(!we_bad, "R6 write lanes", we_bad, 0);
            else begin
                chk(!rd_bad && !we_bad, "R7 read strobe", rd_bad, 0);
                chk(rsp_rdata == last_rd, "R9 read capture", rsp_rdata, last_rd);
            end
        end
        @(negedge clk);
        chk(!req_ack, "R8 ack single cycle", req_ack, 0);
    endtask

    initial begin
        void'($urandom(32'h5bc0_1a7e));
        repeat (3) @(negedge clk);
        chk(&bus_cs_n && bus_rd_n && (&bus_we_n) && !req_ack, "R11 in reset", bus_cs_n, 3);
        rst_n = 1'b1;
        @(negedge clk);
        chk(&bus_cs_n && bus_rd_n && (&bus_we_n) && !req_ack, "R11 after reset", bus_cs_n, 3);
        // Directed corners.
        run_access(0, 1'b0, 8'hFF, 1, 3, 7, 3, 0);   // longest frame, R3
        run_access(1, 1'b1, 8'hFF, 0, 0, 0, 0, 0);   // shortest, 8-bit write, R6
        run_access(1, 1'b0, 8'h0F, 0, 2, 0, 2, 3);   // extension with zero waits, R4
        run_access(2, 1'b1, 8'hFF, 1, 3, 7, 3, 2);   // unmapped, R10
        run_access(0, 1'b1, 8'hA5, 1, 1, 5, 2, 1);   // 32-bit write lanes, R6
        for (int i = 0; i < 300; i++) begin
            int rs = $urandom_range(0, 4);
            run_access((rs > 2) ? rs - 3 : rs, 1'($urandom), BE_W'($urandom) | 8'h01,
                       $urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 7),
                       $urandom_range(0, 3), $urandom_range(0, 3));
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R8 actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule